// File: doc/BRIEF.md
# Interrupt mapping and dispatch controller

This block gathers 64 level-sensitive interrupt lines and presents at most one vectored request to the processor at a time. Lines 0 to 31 come from expansion-bus slots and are enabled in groups of four through a shared mapping register. Lines 32 to 63 come from on-board peripherals and each has a mapping register of its own. A request, once taken, stays asserted on a registered one-hot vector output until software acknowledges it through a clear register, or until the on-board map that owns it is disabled.

Software reaches the mapping and clear registers through a simple register port: a write strobe, an address, write data, and a combinational read-data path. Every register occupies the upper word of an 8-byte pair; the lower word reads as zero and ignores writes. After any map write or any clear that takes effect, the block scans the pending lines again in the following cycle. The scan puts slot lines ahead of on-board lines, and lower numbers ahead of higher numbers within each class.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, vec_out is all-zero and every map register reads with bit 31 clear and its fixed low bits. Slot group g reads 0x7C0 | (4*g). On-board register k reads 0x7E0 + k.
- R2: A write to a map register changes only bit 31 (the enable). Bits 30:0 read back unchanged. An access whose address bit 2 is clear reads zero and has no effect.
- R3: When a slot line rises and its group enable is set, vec_out shows bit n one edge later, even if another request was outstanding. vec_out is one-hot.
- R4: When an on-board line rises, it becomes the request one edge later only if no request is outstanding and its enable is set. Otherwise vec_out does not change.
- R5: A line that is high while its map is disabled stays pending. Enabling the map starts a scan one edge after the write edge, which takes that line if nothing is outstanding.
- R6: A scan keeps an outstanding request unchanged. If nothing is outstanding, it takes the lowest-numbered eligible slot line (0 to 31) first, and only then the lowest eligible on-board line (32 to 63).
- R7: A write to the slot clear window at 0x1400 to 0x14FF selects group (addr[7:5]). It drops the request when request/4 equals that group; vec_out is zero one edge later and a scan follows. A group that does not match leaves vec_out unchanged.
- R8: A write to the on-board clear window at 0x1800 to 0x18FF selects number 32 + addr[7:3]. It drops the request only on an exact match, and a scan follows one edge later.
- R9: Writing an on-board map (window 0x1000 to 0x10FF, register addr[7:3]) with bit 31 clear, while its line is the request, drops the request one edge later.
- R10: A falling line clears only its pending state. The outstanding request stays asserted, and later scans skip the fallen line.
- R11: vec_out has at most one bit set in every cycle.
- R12: The two bus-error map registers (window 0x1100 to 0x110F) read as the constant 0x7F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt levels; bits 31:0 are slot lines, bits 63:32 are on-board lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data; bit 31 is the enable |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| vec_out | output | 64 | Registered one-hot request vector; zero when idle |

## Verification
A rising line and the immediate effect of a clear or map write show on vec_out one clock edge after the stimulus is applied. A scan triggered by a write shows two edges after it, and register reads settle within the same cycle. At each stimulus the driver records the cycle in which each result falls due, counted from the edge count at drive time. The monitor compares vec_out shortly after exactly that edge, so a result that comes one cycle early or late fails. Each test also checks that vec_out holds while a request is blocked or a line falls, not only that it changes.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   localparam int unsigned IDX_W = 5;

   typedef enum logic [2:0] {
      WIN_NONE,
      WIN_SLOT_MAP,
      WIN_OBD_MAP,
      WIN_ERR_MAP,
      WIN_SLOT_CLR,
      WIN_OBD_CLR
   } win_e;

   localparam logic [15:0] SLOT_MAP_LO = 16'h0C00;
   localparam logic [15:0] SLOT_MAP_HI = 16'h0C3F;
   localparam logic [15:0] OBD_MAP_LO  = 16'h1000;
   localparam logic [15:0] OBD_MAP_HI  = 16'h10FF;
   localparam logic [15:0] ERR_MAP_LO  = 16'h1100;
   localparam logic [15:0] ERR_MAP_HI  = 16'h110F;
   localparam logic [15:0] SLOT_CLR_LO = 16'h1400;
   localparam logic [15:0] SLOT_CLR_HI = 16'h14FF;
   localparam logic [15:0] OBD_CLR_LO  = 16'h1800;
   localparam logic [15:0] OBD_CLR_HI  = 16'h18FF;

   // fixed read-only low field of a slot group map
   function automatic int unsigned slot_map_ro(int unsigned grp, int unsigned gsz);
      return (32'h1F << 6) | (grp * gsz);
   endfunction

   // fixed read-only low field of an on-board map
   function automatic int unsigned obd_map_ro(int unsigned k);
      return ((32'h1F << 6) | 32'h20) + k;
   endfunction

   function automatic int unsigned err_map_ro();
      return (32'h1F << 6) | 32'h30;
   endfunction

endpackage

// File: rtl/irqd_regdec.sv
module irqd_regdec
   import irqd_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [IDX_W-1:0]  idx
);

   function automatic logic in_rng(logic [ADDR_W-1:0] a, logic [15:0] lo, logic [15:0] hi);
      return (a >= ADDR_W'(lo)) && (a <= ADDR_W'(hi));
   endfunction

   always_comb begin
      win = WIN_NONE;
      idx = '0;
      if (addr[2]) begin
         if (in_rng(addr, SLOT_MAP_LO, SLOT_MAP_HI)) begin
            win = WIN_SLOT_MAP;
            idx = IDX_W'(addr[5:3]);
         end else if (in_rng(addr, OBD_MAP_LO, OBD_MAP_HI)) begin
            win = WIN_OBD_MAP;
            idx = addr[7:3];
         end else if (in_rng(addr, ERR_MAP_LO, ERR_MAP_HI)) begin
            win = WIN_ERR_MAP;
            idx = IDX_W'(addr[3]);
         end else if (in_rng(addr, SLOT_CLR_LO, SLOT_CLR_HI)) begin
            win = WIN_SLOT_CLR;
            idx = IDX_W'(addr[7:5]);
         end else if (in_rng(addr, OBD_CLR_LO, OBD_CLR_HI)) begin
            win = WIN_OBD_CLR;
            idx = addr[7:3];
         end
      end
   end

endmodule

// File: rtl/irqd_maps.sv
module irqd_maps
   import irqd_pkg::*;
#(
   parameter int unsigned N_GRP  = 8,
   parameter int unsigned GRP_SZ = 4,
   parameter int unsigned N_OBD  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  win_e              win,
   input  logic [IDX_W-1:0]  idx,
   input  logic              en_wr,
   output logic [N_GRP-1:0]  grp_en,
   output logic [N_OBD-1:0]  obd_en,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned LOW_W = DATA_W - 1;

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_slot_en
         always_ff @(posedge clk) begin
            if (!rst_n)
               grp_en[g] <= 1'b0;
            else if (wr && win == WIN_SLOT_MAP && idx == IDX_W'(g))
               grp_en[g] <= en_wr;
         end
      end
      for (genvar k = 0; k < N_OBD; k++) begin : g_obd_en
         always_ff @(posedge clk) begin
            if (!rst_n)
               obd_en[k] <= 1'b0;
            else if (wr && win == WIN_OBD_MAP && idx == IDX_W'(k))
               obd_en[k] <= en_wr;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (win)
         WIN_SLOT_MAP:
            if (int'(idx) < N_GRP)
               rdata = {grp_en[idx], LOW_W'(slot_map_ro(int'(idx), GRP_SZ))};
         WIN_OBD_MAP:
            if (int'(idx) < N_OBD)
               rdata = {obd_en[idx], LOW_W'(obd_map_ro(int'(idx)))};
         WIN_ERR_MAP:
            rdata = {1'b0, LOW_W'(err_map_ro())};
         default:
            rdata = '0;
      endcase
   end

endmodule

// File: rtl/irqd_ffs.sv
module irqd_ffs #(
   parameter int unsigned W     = 64,
   parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   // lowest set bit wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irqd_pkg::*;
#(
   parameter int unsigned N_GRP  = 8,
   parameter int unsigned GRP_SZ = 4,
   parameter int unsigned N_OBD  = 32,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_GRP*GRP_SZ+N_OBD-1:0]  irq_in,
   input  logic                           reg_wr,
   input  logic [ADDR_W-1:0]              reg_addr,
   input  logic [DATA_W-1:0]              reg_wdata,
   output logic [DATA_W-1:0]              reg_rdata,
   output logic [N_GRP*GRP_SZ+N_OBD-1:0]  vec_out
);

   localparam int unsigned N_SLOT = N_GRP * GRP_SZ;
   localparam int unsigned N_IRQ  = N_SLOT + N_OBD;
   localparam int unsigned NUM_W  = $clog2(N_IRQ);
   localparam int unsigned SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
   localparam int unsigned OBD_W  = (N_OBD > 1) ? $clog2(N_OBD) : 1;
   localparam int unsigned GSH    = $clog2(GRP_SZ);

   generate
      if (GRP_SZ != (1 << GSH)) begin : g_bad_grp
         $error("GRP_SZ must be a power of two");
      end
      if (N_GRP > 8 || N_OBD > 32 || N_OBD < 2) begin : g_bad_cnt
         $error("group or on-board count does not fit the register windows");
      end
      if (ADDR_W < 16 || DATA_W < 12) begin : g_bad_w
         $error("address or data width too narrow");
      end
   endgenerate

   win_e              win;
   logic [IDX_W-1:0]  idx;
   logic [N_GRP-1:0]  pci_en_q;
   logic [N_OBD-1:0]  obd_en_q;
   logic [N_IRQ-1:0]  pend_q;
   logic [N_IRQ-1:0]  rise;
   logic [N_IRQ-1:0]  elig;
   logic [N_SLOT-1:0] rise_slot_ok;
   logic [N_OBD-1:0]  rise_obd_ok;
   logic              req_vld_q, req_vld_d;
   logic [NUM_W-1:0]  req_num_q, req_num_d;
   logic              rescan_q, rescan_d;
   logic              scan_hit, slot_hit, obd_hit;
   logic [NUM_W-1:0]  scan_num;
   logic [SLOT_W-1:0] slot_num;
   logic [OBD_W-1:0]  obd_num;
   logic [N_IRQ-1:0]  vec_d;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-2:0];

   irqd_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .win  (win),
      .idx  (idx)
   );

   irqd_maps #(
      .N_GRP  (N_GRP),
      .GRP_SZ (GRP_SZ),
      .N_OBD  (N_OBD),
      .DATA_W (DATA_W)
   ) u_maps (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .win    (win),
      .idx    (idx),
      .en_wr  (reg_wdata[DATA_W-1]),
      .grp_en (pci_en_q),
      .obd_en (obd_en_q),
      .rdata  (reg_rdata)
   );

   assign rise = irq_in & ~pend_q;

   generate
      for (genvar s = 0; s < N_SLOT; s++) begin : g_slot_elig
         assign elig[s]         = pend_q[s] & pci_en_q[s / GRP_SZ];
         assign rise_slot_ok[s] = rise[s] & pci_en_q[s / GRP_SZ];
      end
      for (genvar k = 0; k < N_OBD; k++) begin : g_obd_elig
         assign elig[N_SLOT+k]  = pend_q[N_SLOT+k] & obd_en_q[k];
         assign rise_obd_ok[k]  = rise[N_SLOT+k] & obd_en_q[k];
      end
   endgenerate

   // full scan: slot lines occupy the low bits, so they win
   irqd_ffs #(.W(N_IRQ), .IDX_W(NUM_W)) u_scan (
      .vec   (elig),
      .found (scan_hit),
      .idx   (scan_num)
   );

   irqd_ffs #(.W(N_SLOT), .IDX_W(SLOT_W)) u_slot_rise (
      .vec   (rise_slot_ok),
      .found (slot_hit),
      .idx   (slot_num)
   );

   irqd_ffs #(.W(N_OBD), .IDX_W(OBD_W)) u_obd_rise (
      .vec   (rise_obd_ok),
      .found (obd_hit),
      .idx   (obd_num)
   );

   logic             req_is_slot;
   logic [NUM_W-1:0] req_grp;
   logic [NUM_W-1:0] req_obd;
   logic             slot_clr_hit, obd_clr_hit, obd_map_off_hit;

   assign req_is_slot     = req_num_q < NUM_W'(N_SLOT);
   assign req_grp         = req_num_q >> GSH;
   assign req_obd         = req_num_q - NUM_W'(N_SLOT);
   assign slot_clr_hit    = reg_wr && win == WIN_SLOT_CLR && req_vld_q && req_is_slot
                            && req_grp == NUM_W'(idx);
   assign obd_clr_hit     = reg_wr && win == WIN_OBD_CLR && req_vld_q && !req_is_slot
                            && req_obd == NUM_W'(idx);
   assign obd_map_off_hit = reg_wr && win == WIN_OBD_MAP && !reg_wdata[DATA_W-1]
                            && req_vld_q && !req_is_slot && req_obd == NUM_W'(idx);

   always_comb begin
      req_vld_d = req_vld_q;
      req_num_d = req_num_q;
      rescan_d  = 1'b0;
      if (rescan_q && !req_vld_q && scan_hit) begin
         req_vld_d = 1'b1;
         req_num_d = scan_num;
      end
      if (slot_clr_hit || obd_clr_hit) begin
         req_vld_d = 1'b0;
         rescan_d  = 1'b1;
      end
      if (obd_map_off_hit)
         req_vld_d = 1'b0;
      if (reg_wr && (win == WIN_SLOT_MAP || win == WIN_OBD_MAP))
         rescan_d = 1'b1;
      if (slot_hit) begin
         req_vld_d = 1'b1;
         req_num_d = NUM_W'(slot_num);
      end else if (obd_hit && !req_vld_d) begin
         req_vld_d = 1'b1;
         req_num_d = NUM_W'(obd_num) + NUM_W'(N_SLOT);
      end
   end

   always_comb begin
      vec_d = '0;
      if (req_vld_d)
         vec_d[req_num_d] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= '0;
         req_vld_q <= 1'b0;
         req_num_q <= '0;
         rescan_q  <= 1'b0;
         vec_out   <= '0;
      end else begin
         pend_q    <= irq_in;
         req_vld_q <= req_vld_d;
         req_num_q <= req_num_d;
         rescan_q  <= rescan_d;
         vec_out   <= vec_d;
      end
   end

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
   parameter int unsigned N_GRP  = 8,
   parameter int unsigned GRP_SZ = 4,
   parameter int unsigned N_OBD  = 32
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [N_GRP*GRP_SZ+N_OBD-1:0]  irq_in,
   input logic                           reg_wr,
   input logic [N_GRP*GRP_SZ+N_OBD-1:0]  vec_out,
   input logic [N_GRP-1:0]               pci_en
);

   localparam int unsigned N_SLOT = N_GRP * GRP_SZ;
   localparam int unsigned N_IRQ  = N_SLOT + N_OBD;

   logic [N_IRQ-1:0]  prev_in;
   logic              prev_wr;
   logic [N_SLOT-1:0] en_line;
   logic [N_SLOT-1:0] slot_up;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_in <= '0;
         prev_wr <= 1'b0;
      end else begin
         prev_in <= irq_in;
         prev_wr <= reg_wr;
      end
   end

   generate
      for (genvar s = 0; s < N_SLOT; s++) begin : g_en
         assign en_line[s] = pci_en[s / GRP_SZ];
      end
   endgenerate

   assign slot_up = irq_in[N_SLOT-1:0] & ~prev_in[N_SLOT-1:0];

   assert_onehot_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vec_out));

   assert_slot_rise_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(slot_up & en_line)) |=> (|vec_out[N_SLOT-1:0]));

   assert_request_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((|vec_out) && !reg_wr && slot_up == '0) |=> $stable(vec_out));

   assert_idle_needs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_out == '0 && irq_in == prev_in && !reg_wr && !prev_wr) |=> vec_out == '0);

endmodule

bind irq_dispatch irq_dispatch_chk #(
   .N_GRP  (N_GRP),
   .GRP_SZ (GRP_SZ),
   .N_OBD  (N_OBD)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_in  (irq_in),
   .reg_wr  (reg_wr),
   .vec_out (vec_out),
   .pci_en  (pci_en_q)
);

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] vec_out;

   int unsigned cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   typedef struct {
      int unsigned due;
      logic [63:0] val;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   irq_dispatch u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .vec_out   (vec_out)
   );

   always #2.5 clk = ~clk;

   // monitor: compare due items shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         cyc = cyc + 1;
         #1;
         for (int i = 0; i < sbq.size(); ) begin
            if (sbq[i].due <= cyc) begin
               n_chk++;
               if (vec_out !== sbq[i].val) begin
                  n_fail++;
                  $display("FAIL %s: vec_out=%h expected %h (cycle %0d)",
                           sbq[i].tag, vec_out, sbq[i].val, cyc);
               end
               sbq.delete(i);
            end else begin
               i++;
            end
         end
      end
   end

   function automatic logic [63:0] v(int n);
      return 64'd1 << n;
   endfunction

   task automatic expect_vec(int unsigned off, logic [63:0] val, string tag);
      exp_t e;
      e.due = cyc + off;
      e.val = val;
      e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(logic [15:0] a, logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      step();
      reg_wr    = 1'b0;
   endtask

   task automatic rd_check(logic [15:0] a, logic [31:0] exp, string tag);
      reg_addr = a;
      #1;
      n_chk++;
      if (reg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: rdata@%h=%h expected %h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      finish_run();
   end

   initial begin
      step();
      repeat (3) step();
      rst_n = 1'b1;
      expect_vec(1, 64'd0, "R1 idle after reset");
      step();
      rd_check(16'h0C1C, 32'h0000_07CC, "R1 slot map 3");
      rd_check(16'h102C, 32'h0000_07E5, "R1 onboard map 5");
      rd_check(16'h0C18, 32'h0, "R2 even word reads zero");
      rd_check(16'h1104, 32'h0000_07F0, "R12 error map 0");
      rd_check(16'h110C, 32'h0000_07F0, "R12 error map 1");

      wr(16'h0C0C, 32'hFFFF_FFFF);
      rd_check(16'h0C0C, 32'h8000_07C4, "R2 only enable bit written");
      wr(16'h0C00, 32'hFFFF_FFFF);
      rd_check(16'h0C04, 32'h0000_07C0, "R2 even word write ignored");

      irq_in[5] = 1'b1;
      expect_vec(1, v(5), "R3/R11 slot rise one-hot");
      step();

      expect_vec(2, v(5), "R6 scan keeps outstanding");
      wr(16'h1044, 32'h8000_0000);
      rd_check(16'h1044, 32'h8000_07E8, "R2 onboard enable");

      irq_in[40] = 1'b1;
      expect_vec(1, v(5), "R4 onboard blocked");
      step();
      step();

      wr(16'h0C04, 32'h8000_0000);
      step();
      irq_in[2] = 1'b1;
      expect_vec(1, v(2), "R3 slot preempts");
      step();

      irq_in[2] = 1'b0;
      expect_vec(1, v(2), "R10 fall keeps request");
      expect_vec(2, v(2), "R10 fall keeps request");
      step();
      step();

      expect_vec(1, v(2), "R7 other group no effect");
      wr(16'h1424, 32'h0);
      expect_vec(1, 64'd0, "R7 group clear");
      expect_vec(2, v(5), "R10 fallen line skipped by scan");
      wr(16'h1404, 32'h0);
      step();

      irq_in[5] = 1'b0;
      step();
      expect_vec(1, 64'd0, "R7 group 1 clear");
      expect_vec(2, v(40), "R6 onboard after slots");
      wr(16'h1424, 32'h0);
      step();

      expect_vec(1, v(40), "R8 mismatch no effect");
      wr(16'h184C, 32'h0);
      expect_vec(1, 64'd0, "R8 exact clear");
      expect_vec(2, v(40), "R8 rescan retakes");
      wr(16'h1844, 32'h0);
      step();

      expect_vec(1, 64'd0, "R9 disable drops request");
      expect_vec(2, 64'd0, "R9 disabled line not retaken");
      wr(16'h1044, 32'h0);
      step();

      irq_in[40] = 1'b0;
      irq_in[50] = 1'b1;
      irq_in[33] = 1'b1;
      expect_vec(1, 64'd0, "R5 disabled lines stay idle");
      step();
      expect_vec(2, v(50), "R5 enable starts scan");
      wr(16'h1094, 32'h8000_0000);
      step();
      expect_vec(2, v(50), "R6 outstanding kept on map write");
      wr(16'h100C, 32'h8000_0000);
      step();
      expect_vec(1, 64'd0, "R8 clear 50");
      expect_vec(2, v(33), "R6 lowest onboard first");
      wr(16'h1894, 32'h0);
      step();

      irq_in[50] = 1'b0;
      irq_in[33] = 1'b0;
      step();
      expect_vec(1, 64'd0, "R8 clear 33");
      expect_vec(2, 64'd0, "R6 nothing eligible");
      wr(16'h180C, 32'h0);
      step();

      irq_in[7] = 1'b1;
      irq_in[1] = 1'b1;
      expect_vec(1, v(1), "R6 lowest slot rise");
      step();
      irq_in[1] = 1'b0;
      step();
      expect_vec(1, 64'd0, "R7 clear group 0");
      expect_vec(2, v(7), "R7 rescan takes 7");
      wr(16'h1404, 32'h0);
      step();

      irq_in[7] = 1'b0;
      step();
      expect_vec(2, 64'd0, "R7 clear group 1 idle");
      wr(16'h1424, 32'h0);
      step();
      irq_in[50] = 1'b1;
      expect_vec(1, v(50), "R4 onboard accepted when idle");
      step();
      step();

      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      expect_vec(1, 64'd0, "R1 idle after second reset");
      expect_vec(2, 64'd0, "R1 disabled after reset");
      step();
      rd_check(16'h0C0C, 32'h0000_07C4, "R1 enable cleared, low bits kept");
      rd_check(16'h1094, 32'h0000_07F2, "R1 onboard enable cleared");

      repeat (4) step();
      finish_run();
   end

endmodule